// File: doc/BRIEF.md
# Serial Synthesizer Configuration Loader

This block receives the divider settings of a clock synthesizer over three serial wires: a data line, a shift clock and a load strobe. All three are asynchronous to the block clock. Each line passes through a synchronizer chain, and rising edges of the shift clock and the strobe are turned into single-cycle events. Every shift event pushes one data bit into an 18-bit frame register, most significant bit first. A load event copies the frame into holding registers that drive the divider settings:

- a 5-bit input prescaler value,
- a 3-bit output divider code,
- a 10-bit feedback multiplier.

The output divider code has three reserved values. When a load carries one of them, the previous code is kept and an error flag is raised. The prescaler and multiplier fields are taken from that load all the same. A decoded output divide ratio, equal to two raised to the code, is also driven.

Top module: `synth_cfg_loader`

## Requirements
- R1: After reset the outputs are prescaler 5'b11011, multiplier 10'b1100100000, divider code 3'b011, divide ratio 8 and error flag 0.
- R2: Each rising edge of `ser_clk` shifts the current `ser_data` level into the frame, most significant bit first. When a frame is loaded, the first of the last 18 bits shifted becomes prescaler bit 4, and the wire order is prescaler bits 4..0, then code bits 2..0, then multiplier bits 9..0.
- R3: The outputs change only as a result of a rising edge on `ser_load`. Shifting bits without a load leaves every output unchanged.
- R4: A load applies the last 18 bits shifted, so surplus leading bits fall off. A load with no bits shifted since reset reapplies the reset configuration.
- R5: If a loaded code is 3'b000, 3'b110 or 3'b111, the divider code keeps its previous value, the error flag becomes 1, and the prescaler and multiplier take the new fields.
- R6: A load with a valid code (3'b001 to 3'b101) clears the error flag.
- R7: `out_ratio` equals 2 to the power of the held divider code (2, 4, 8, 16 or 32).
- R8: The outputs reflect a load at the third rising `clk` edge that samples `ser_load` high, counting that first sampling edge (SYNC_STAGES + 1 edges), and not earlier.
- R9: A strobe or shift clock held high acts once. Holding `ser_load` high while new bits are shifted does not apply them, and a long `ser_clk` high phase shifts one bit only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock; a bit is taken on its rising edge |
| ser_load | input | 1 | Load strobe; the frame is applied on its rising edge |
| pre_div | output | 5 | Held input prescaler value |
| fb_mult | output | 10 | Held feedback multiplier |
| out_code | output | 3 | Held output divider code |
| out_ratio | output | 6 | Decoded output divide ratio |
| code_err | output | 1 | Last load carried a reserved divider code |

## Verification
The frame register cannot be seen until a load happens. A wrong bit order, a doubled or missed shift, or a wrong field split therefore shows up only on the first load after the fault, three clocks after the strobe is sampled, as a wrong field value. A wrong synchronizer depth or edge-detect slip shows up the same way, as an output change one cycle early or late. The bench model tracks the expected frame and holding state on every clock and compares all five outputs on every cycle, so any such fault is reported in the cycle it first reaches the ports.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int P_W     = 5;
  localparam int N_W     = 3;
  localparam int M_W     = 10;
  localparam int FRAME_W = P_W + N_W + M_W;
  localparam int R_W     = 6;

  typedef struct packed {
    logic [P_W-1:0] pre;
    logic [N_W-1:0] ncode;
    logic [M_W-1:0] mult;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{pre: 5'b11011, ncode: 3'b011, mult: 10'b1100100000};

  function automatic logic n_code_ok(input logic [N_W-1:0] n);
    case (n)
      3'b000, 3'b110, 3'b111: n_code_ok = 1'b0;
      default:                n_code_ok = 1'b1;
    endcase
  endfunction

  function automatic logic [R_W-1:0] ratio_of(input logic [N_W-1:0] n);
    ratio_of = {{(R_W-1){1'b0}}, 1'b1} << n;
  endfunction

  function automatic cfg_t unpack_frame(input logic [FRAME_W-1:0] f);
    unpack_frame = cfg_t'(f);
  endfunction
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] level
);
  logic [LINES-1:0] chain [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= raw;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign level = chain[STAGES-1];
endmodule

// File: rtl/edge_detect.sv
module edge_detect #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;

  assign rise = lvl & ~prev_q;

  // R9: a level held high yields one event only
  p_rise_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_evt,
  input  logic               data_bit,
  output logic [FRAME_W-1:0] word
);
  logic [FRAME_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         word_q <= FRAME_W'(CFG_DEFAULT);
    else if (shift_evt) word_q <= {word_q[FRAME_W-2:0], data_bit};

  assign word = word_q;

  // R2: newest bit enters at the bottom, older bits move up by one
  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> (word_q[0] == $past(data_bit)) &&
                  (word_q[FRAME_W-1:1] == $past(word_q[FRAME_W-2:0])));
  p_shift_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_evt |=> $stable(word_q));
endmodule

// File: rtl/cfg_holder.sv
module cfg_holder
  import cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_evt,
  input  logic [FRAME_W-1:0] word,
  output cfg_t               cfg,
  output logic               code_err
);
  cfg_t cfg_q;
  cfg_t incoming;
  logic incoming_ok;
  logic err_q;

  assign incoming    = unpack_frame(word);
  assign incoming_ok = n_code_ok(incoming.ncode);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_q <= CFG_DEFAULT;
      err_q <= 1'b0;
    end else if (load_evt) begin
      cfg_q.pre  <= incoming.pre;
      cfg_q.mult <= incoming.mult;
      if (incoming_ok) cfg_q.ncode <= incoming.ncode;
      err_q <= !incoming_ok;
    end

  assign cfg      = cfg_q;
  assign code_err = err_q;

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(cfg_q) && $stable(err_q));
  p_bad_code_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !incoming_ok) |=> err_q && (cfg_q.ncode == $past(cfg_q.ncode)));
  p_never_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    n_code_ok(cfg_q.ncode));
  p_good_code_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && incoming_ok) |=> !err_q && (cfg_q.ncode == $past(incoming.ncode)));
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_data,
  input  logic           ser_clk,
  input  logic           ser_load,
  output logic [P_W-1:0] pre_div,
  output logic [M_W-1:0] fb_mult,
  output logic [N_W-1:0] out_code,
  output logic [R_W-1:0] out_ratio,
  output logic           code_err
);
  localparam int L_DATA = 0;
  localparam int L_CLK  = 1;
  localparam int L_LOAD = 2;
  localparam int LINES  = 3;

  logic [LINES-1:0]   lvl;
  logic [1:0]         rise;
  logic               shift_evt;
  logic               load_evt;
  logic [FRAME_W-1:0] word;
  cfg_t               cfg;

  line_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .raw({ser_load, ser_clk, ser_data}), .level(lvl));

  edge_detect #(.W(2)) u_edges (
    .clk(clk), .rst_n(rst_n), .lvl(lvl[L_LOAD:L_CLK]), .rise(rise));

  assign shift_evt = rise[0];
  assign load_evt  = rise[1];

  frame_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .shift_evt(shift_evt),
    .data_bit(lvl[L_DATA]), .word(word));

  cfg_holder u_hold (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .word(word),
    .cfg(cfg), .code_err(code_err));

  assign pre_div   = cfg.pre;
  assign fb_mult   = cfg.mult;
  assign out_code  = cfg.ncode;
  assign out_ratio = ratio_of(cfg.ncode);

  // R7: the ratio is a single power of two between 2 and 32
  p_ratio_pow2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(out_ratio) == 1) && !out_ratio[0]);
endmodule

// File: tb/synth_cfg_loader_test.sv
module synth_cfg_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int FW         = 18;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_load = 1'b0;
  logic [4:0] pre_div;
  logic [9:0] fb_mult;
  logic [2:0] out_code;
  logic [5:0] out_ratio;
  logic       code_err;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_cfg_loader #(.SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_load(ser_load), .pre_div(pre_div), .fb_mult(fb_mult),
    .out_code(out_code), .out_ratio(out_ratio), .code_err(code_err));

  // reference model: sample history queues and a behavioural frame
  bit hd [$], hc [$], hl [$];
  int m_frame, m_p, m_n, m_m;
  bit m_err;

  task automatic model_reset();
    hd = {}; hc = {}; hl = {};
    for (int i = 0; i <= SYNC; i++) begin hd.push_back(0); hc.push_back(0); hl.push_back(0); end
    m_p = 27; m_n = 3; m_m = 800; m_err = 0;
    m_frame = (27 << 13) | (3 << 10) | 800;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) model_reset();
    else begin
      if (hl[SYNC-1] && !hl[SYNC]) begin
        int nn;
        nn = (m_frame >> 10) & 7;
        m_p = (m_frame >> 13) & 31;
        m_m = m_frame & 1023;
        if (nn == 0 || nn == 6 || nn == 7) m_err = 1;
        else begin m_n = nn; m_err = 0; end
      end
      if (hc[SYNC-1] && !hc[SYNC])
        m_frame = ((m_frame << 1) | int'(hd[SYNC-1])) & ((1 << FW) - 1);
      void'(hd.pop_back()); void'(hc.pop_back()); void'(hl.pop_back());
      hd.push_front(ser_data); hc.push_front(ser_clk); hl.push_front(ser_load);
    end
  end

  always @(negedge clk) begin
    compared++;
    if (pre_div != m_p[4:0] || fb_mult != m_m[9:0] || out_code != m_n[2:0] ||
        out_ratio != 6'(1 << m_n) || code_err != m_err) begin
      mismatched++;
      $display("FAIL R3 cycle %0d: got p=%0d m=%0d n=%0d r=%0d e=%0d expected p=%0d m=%0d n=%0d r=%0d e=%0d",
               cycles, pre_div, fb_mult, out_code, out_ratio, code_err,
               m_p, m_m, m_n, 1 << m_n, m_err);
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk)
    if (cycles == WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog: act=hung exp=finished");
      summary();
    end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_cfg(input string tag, input int p, input int n, input int m, input int e);
    chk({tag, " pre"}, pre_div, p);
    chk({tag, " code"}, out_code, n);
    chk({tag, " mult"}, fb_mult, m);
    chk({tag, " err"}, code_err, e);
  endtask

  task automatic ser_bit(input bit b, input int hi);
    @(negedge clk) ser_data = b;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (hi) @(negedge clk);
    ser_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [FW-1:0] f, input int hi);
    for (int i = FW-1; i >= 0; i--) ser_bit(f[i], hi);
  endtask

  task automatic pulse_load();
    repeat (3) @(negedge clk);
    ser_load = 1'b1;
    repeat (4) @(negedge clk);
    ser_load = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [FW-1:0] mk(input int p, input int n, input int m);
    mk = {5'(p), 3'(n), 10'(m)};
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_cfg("R1 reset", 27, 3, 800, 0);
    chk("R1 ratio", out_ratio, 8);

    send(mk(25, 2, 576), 2);
    chk_cfg("R3 shift without load", 27, 3, 800, 0);
    pulse_load();
    chk_cfg("R2 field order", 25, 2, 576, 0);
    chk("R7 ratio code 2", out_ratio, 4);

    send(mk(27, 1, 850), 2);
    @(negedge clk) ser_load = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 not yet after two edges", fb_mult, 576);
    @(negedge clk);
    chk("R8 applied at third edge", fb_mult, 850);
    ser_load = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 ratio code 1", out_ratio, 2);

    send(mk(21, 6, 341), 2);
    pulse_load();
    chk_cfg("R5 code 110", 21, 1, 341, 1);
    send(mk(3, 0, 7), 2);
    pulse_load();
    chk_cfg("R5 code 000", 3, 1, 7, 1);
    send(mk(31, 7, 1023), 2);
    pulse_load();
    chk_cfg("R5 code 111", 31, 1, 1023, 1);

    send(mk(27, 5, 425), 2);
    pulse_load();
    chk_cfg("R6 valid clears", 27, 5, 425, 0);
    chk("R7 ratio code 5", out_ratio, 32);

    ser_bit(1'b1, 2);
    ser_bit(1'b1, 2);
    send(mk(25, 3, 625), 2);
    pulse_load();
    chk_cfg("R4 surplus bits dropped", 25, 3, 625, 0);

    repeat (3) @(negedge clk);
    ser_load = 1'b1;
    repeat (6) @(negedge clk);
    send(mk(27, 2, 1000), 12);
    chk_cfg("R9 held strobe no reload", 25, 3, 625, 0);
    ser_load = 1'b0;
    repeat (4) @(negedge clk);
    pulse_load();
    chk_cfg("R9 long clock high one shift", 27, 2, 1000, 0);

    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pulse_load();
    chk_cfg("R4 load after reset", 27, 3, 800, 0);

    repeat (5) @(negedge clk);
    summary();
  end
endmodule